// File: doc/BRIEF.md
# Ten-Bit Carry-Select Adder/Subtractor Slice

The slice adds or subtracts two 10-bit operands and registers the result, a carry-out and a signed-overflow flag on the next clock edge. Ten arithmetic cells each work out their sum bit and carry-out twice, once assuming an incoming carry of 0 and once assuming 1, before the real carry is known. Each cell hands both carry-outs to its neighbour. The cells are split into two groups of five. At the top of each group, the carry actually entering that group selects between the two precomputed results.

A runtime control picks the operation. When subtraction is requested, every bit of `op_a` is inverted and the effective carry-in is forced to 1, so the slice produces `op_b - op_a` in two's complement. A 4-bit start index sets the lowest cell of the chain. Cells below the start index copy `op_b` through and pass the carry on unchanged. Wider operands are built by feeding `cout_q` of one slice into `grp_cin` of the next.

Top module: `addsub_slice`

## Requirements
- R1: With `sub_en`=0 and start index 0, `{cout_q,sum_q}` equals `op_a + op_b + grp_cin` one clock after the inputs are applied.
- R2: With `sub_en`=1, every bit of `op_a` is inverted and the carry into the chain is 1 regardless of `grp_cin`. With start index 0, `sum_q` is `op_b - op_a` modulo 1024.
- R3: `cout_q` is the carry out of bit 9. In subtraction it is 1 exactly when no borrow occurs, which at start index 0 means `op_b >= op_a` (unsigned).
- R4: For a start index s in 0..9, `sum_q[s-1:0]` equals `op_b[s-1:0]`. `sum_q[9:s]` equals `op_b[9:s] + a'[9:s] + c`, where a' is the possibly inverted `op_a` and c is the effective carry-in.
- R5: For a start index of 10 to 15, no cell is active. `sum_q` equals `op_b`, `cout_q` equals the effective carry-in (`sub_en | grp_cin`), and `ovf_q` is 0.
- R6: When at least one cell is active, `ovf_q` is the XOR of the carry entering bit 9 and the carry leaving bit 9. For an addition at start index 0, this flags a sum whose sign differs from the sign shared by both operands.
- R7: While `rst_n` is low, `sum_q`, `cout_q` and `ovf_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 10 | Operand that is inverted when subtracting |
| op_b | input | 10 | Operand that is passed through by inactive cells |
| sub_en | input | 1 | 1 selects `op_b - op_a`, 0 selects addition |
| grp_cin | input | 1 | Group carry-in, used only when adding |
| start_idx | input | 4 | Lowest active cell; a value of 10 or more disables all cells |
| sum_q | output | 10 | Registered sum |
| cout_q | output | 1 | Registered carry out of the chain |
| ovf_q | output | 1 | Registered signed-overflow flag |

## Verification
Additions are driven with carries that stop inside the lower group, cross the boundary between cell 4 and cell 5, and ripple through all ten bits. This separates a wrong carry-select choice from a wrong cell. Subtractions with equal, larger and smaller subtrahends exercise the inverted operand, the forced carry and the borrow sense of the carry-out. Start indices at 0, inside each group, at 9 and beyond 9 check the pass-through bits and the carry that bypasses inactive cells. Operand pairs at the edges of the signed range, together with random operands, modes and start indices, are compared against a bit-serial ripple model written in the bench.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  // {carry, sum} of a single-bit full add
  function automatic logic [1:0] bit_add(input logic a, input logic b, input logic c);
    bit_add = {(a & b) | (a & c) | (b & c), a ^ b ^ c};
  endfunction

  // pick the precomputed pair that matches the carry seen on a chain
  function automatic logic [1:0] pick_pair(input logic c, input logic [1:0] if0,
                                           input logic [1:0] if1);
    pick_pair = c ? if1 : if0;
  endfunction
endpackage

// File: rtl/addsub_cell.sv
module addsub_cell
  import addsub_pkg::*;
(
  input  logic a_bit,
  input  logic b_bit,
  input  logic active,
  input  logic cin_lo,   // carry on the chain that assumes group carry 0
  input  logic cin_hi,   // carry on the chain that assumes group carry 1
  output logic sum_lo,
  output logic sum_hi,
  output logic cout_lo,
  output logic cout_hi
);
  logic [1:0] pre0, pre1, sel_lo, sel_hi;

  always_comb begin
    pre0   = bit_add(a_bit, b_bit, 1'b0);
    pre1   = bit_add(a_bit, b_bit, 1'b1);
    sel_lo = pick_pair(cin_lo, pre0, pre1);
    sel_hi = pick_pair(cin_hi, pre0, pre1);
    if (active) begin
      {cout_lo, sum_lo} = sel_lo;
      {cout_hi, sum_hi} = sel_hi;
    end else begin
      sum_lo  = b_bit;
      sum_hi  = b_bit;
      cout_lo = cin_lo;
      cout_hi = cin_hi;
    end
  end
endmodule

// File: rtl/addsub_group.sv
module addsub_group #(
  parameter int CELLS = 5
) (
  input  logic [CELLS-1:0] a_vec,
  input  logic [CELLS-1:0] b_vec,
  input  logic [CELLS-1:0] act_vec,
  input  logic             grp_c,
  output logic [CELLS-1:0] sum_vec,
  output logic             grp_co,
  output logic             top_cin   // carry entering the top cell
);
  logic [CELLS:0]   c_lo, c_hi;
  logic [CELLS-1:0] s_lo, s_hi;

  assign c_lo[0] = 1'b0;
  assign c_hi[0] = 1'b1;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    addsub_cell u_cell (
      .a_bit  (a_vec[i]),
      .b_bit  (b_vec[i]),
      .active (act_vec[i]),
      .cin_lo (c_lo[i]),
      .cin_hi (c_hi[i]),
      .sum_lo (s_lo[i]),
      .sum_hi (s_hi[i]),
      .cout_lo(c_lo[i+1]),
      .cout_hi(c_hi[i+1])
    );
  end

  // carry-select point at the top of the group
  assign sum_vec = grp_c ? s_hi : s_lo;
  assign grp_co  = grp_c ? c_hi[CELLS] : c_lo[CELLS];
  assign top_cin = grp_c ? c_hi[CELLS-1] : c_lo[CELLS-1];
endmodule

// File: rtl/addsub_slice.sv
module addsub_slice #(
  parameter int CELLS_PER_GROUP = 5,
  parameter int GROUPS          = 2,
  parameter int IDX_W           = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [CELLS_PER_GROUP*GROUPS-1:0]   op_a,
  input  logic [CELLS_PER_GROUP*GROUPS-1:0]   op_b,
  input  logic                                sub_en,
  input  logic                                grp_cin,
  input  logic [IDX_W-1:0]                    start_idx,
  output logic [CELLS_PER_GROUP*GROUPS-1:0]   sum_q,
  output logic                                cout_q,
  output logic                                ovf_q
);
  localparam int W = CELLS_PER_GROUP * GROUPS;

  // named internal events
  logic             eff_cin;
  logic [W-1:0]     a_x;
  logic [W-1:0]     act;
  logic [W-1:0]     sum_w;
  logic [GROUPS:0]  gcar;
  logic [GROUPS-1:0] gtop;
  logic             msb_cin_w;
  logic             ovf_w;

  assign eff_cin = sub_en | grp_cin;
  assign a_x     = op_a ^ {W{sub_en}};

  for (genvar i = 0; i < W; i++) begin : g_act
    assign act[i] = (32'(start_idx) <= i);
  end

  assign gcar[0] = eff_cin;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    addsub_group #(.CELLS(CELLS_PER_GROUP)) u_grp (
      .a_vec  (a_x[g*CELLS_PER_GROUP +: CELLS_PER_GROUP]),
      .b_vec  (op_b[g*CELLS_PER_GROUP +: CELLS_PER_GROUP]),
      .act_vec(act[g*CELLS_PER_GROUP +: CELLS_PER_GROUP]),
      .grp_c  (gcar[g]),
      .sum_vec(sum_w[g*CELLS_PER_GROUP +: CELLS_PER_GROUP]),
      .grp_co (gcar[g+1]),
      .top_cin(gtop[g])
    );
  end

  assign msb_cin_w = gtop[GROUPS-1];
  assign ovf_w     = act[W-1] & (msb_cin_w ^ gcar[GROUPS]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      sum_q  <= sum_w;
      cout_q <= gcar[GROUPS];
      ovf_q  <= ovf_w;
    end
  end
endmodule

// File: rtl/addsub_slice_chk.sv
module addsub_slice_chk #(
  parameter int W     = 10,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     op_a,
  input logic [W-1:0]     op_b,
  input logic             sub_en,
  input logic             grp_cin,
  input logic [IDX_W-1:0] start_idx,
  input logic [W-1:0]     sum_q,
  input logic             cout_q,
  input logic             ovf_q
);
  // R1
  full_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_idx == '0 && !sub_en) |=>
      ({cout_q, sum_q} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)} + {{W{1'b0}}, $past(grp_cin)})));

  // R2
  full_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_idx == '0 && sub_en) |=> (sum_q == W'($past(op_b) - $past(op_a))));

  // R3
  no_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_idx == '0 && sub_en) |=> (cout_q == ($past(op_b) >= $past(op_a))));

  // R4
  low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(start_idx) < W) |=>
      (((sum_q ^ $past(op_b)) & ((W'(1) << $past(start_idx)) - W'(1))) == '0));

  // R5
  empty_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(start_idx) >= W) |=>
      (sum_q == $past(op_b) && cout_q == $past(sub_en | grp_cin) && !ovf_q));

  // R6
  add_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_idx == '0 && !sub_en) |=>
      (ovf_q == (($past(op_a[W-1]) == $past(op_b[W-1])) && (sum_q[W-1] != $past(op_a[W-1])))));

  // R7
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (sum_q == '0 && !cout_q && !ovf_q);
    end
  end
endmodule

bind addsub_slice addsub_slice_chk #(.W(W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sub_en(sub_en),
  .grp_cin(grp_cin), .start_idx(start_idx), .sum_q(sum_q), .cout_q(cout_q),
  .ovf_q(ovf_q)
);

// File: tb/addsub_slice_bench.sv
module addsub_slice_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] op_a = '0, op_b = '0;
  logic       sub_en = 1'b0, grp_cin = 1'b0;
  logic [3:0] start_idx = '0;
  logic [9:0] sum_q;
  logic       cout_q, ovf_q;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  addsub_slice u_addsub_slice (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sub_en(sub_en),
    .grp_cin(grp_cin), .start_idx(start_idx), .sum_q(sum_q), .cout_q(cout_q),
    .ovf_q(ovf_q)
  );

  // bit-serial ripple model: returns {ovf, cout, sum}
  function automatic logic [11:0] model(input logic [9:0] a, input logic [9:0] b,
                                        input logic sub, input logic ci, input int s);
    logic [9:0] r;
    logic c, c9;
    c = sub ? 1'b1 : ci;
    c9 = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (i < s) r[i] = b[i];
      else begin
        logic ab;
        ab = a[i] ^ sub;
        if (i == 9) c9 = c;
        r[i] = ab ^ b[i] ^ c;
        c = (ab & b[i]) | (c & (ab ^ b[i]));
      end
    end
    model = {(s <= 9) ? (c9 ^ c) : 1'b0, c, r};
  endfunction

  task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got ovf=%0b cout=%0b sum=%h, expected ovf=%0b cout=%0b sum=%h",
               tag, got[11], got[10], got[9:0], exp[11], exp[10], exp[9:0]);
    end
  endtask

  // apply on a falling edge, sample at the falling edge after the capturing rise
  task automatic run_op(input string tag, input logic [9:0] a, input logic [9:0] b,
                        input logic sub, input logic ci, input logic [3:0] s);
    @(negedge clk);
    op_a = a; op_b = b; sub_en = sub; grp_cin = ci; start_idx = s;
    @(negedge clk);
    check(tag, {ovf_q, cout_q, sum_q}, model(a, b, sub, ci, int'(s)));
  endtask

  task automatic t_reset;  // R7
    op_a = 10'h3ff; op_b = 10'h3ff; grp_cin = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 reset", {ovf_q, cout_q, sum_q}, 12'h000);
    rst_n = 1'b1;
  endtask

  task automatic t_add;  // R1 R3
    run_op("R1 zero", 10'h000, 10'h000, 0, 0, 0);
    run_op("R1 carry stays low group", 10'h003, 10'h005, 0, 0, 0);
    run_op("R1 cross cell4-cell5", 10'h01f, 10'h001, 0, 0, 0);
    run_op("R1 grp_cin ripple", 10'h000, 10'h3ff, 0, 1, 0);
    run_op("R3 full carry out", 10'h3ff, 10'h001, 0, 0, 0);
  endtask

  task automatic t_sub;  // R2 R3
    run_op("R2 equal", 10'h155, 10'h155, 1, 0, 0);
    run_op("R2 grp_cin ignored", 10'h011, 10'h100, 1, 0, 0);
    run_op("R2 grp_cin set", 10'h011, 10'h100, 1, 1, 0);
    run_op("R3 borrow", 10'h100, 10'h011, 1, 0, 0);
  endtask

  task automatic t_start;  // R4 R5
    run_op("R4 start 3", 10'h3ff, 10'h2a5, 0, 1, 3);
    run_op("R4 start 5 upper group only", 10'h0ff, 10'h1e7, 0, 0, 5);
    run_op("R4 start 9", 10'h200, 10'h200, 0, 1, 9);
    run_op("R4 start 7 subtract", 10'h0c0, 10'h040, 1, 0, 7);
    run_op("R5 start 10 add", 10'h3ff, 10'h123, 0, 1, 10);
    run_op("R5 start 15 subtract", 10'h3ff, 10'h0f0, 1, 0, 15);
  endtask

  task automatic t_ovf;  // R6
    run_op("R6 pos+pos", 10'h1ff, 10'h001, 0, 0, 0);
    run_op("R6 neg+neg", 10'h200, 10'h200, 0, 0, 0);
    run_op("R6 mixed no ovf", 10'h1ff, 10'h3ff, 0, 0, 0);
    run_op("R6 sub min-1", 10'h001, 10'h200, 1, 0, 0);
    run_op("R6 start 9 single bit", 10'h200, 10'h000, 0, 1, 9);
  endtask

  task automatic t_random;  // R1 R2 R4 R6
    for (int k = 0; k < 400; k++) begin
      run_op("R4 random", 10'($urandom), 10'($urandom), 1'($urandom),
             1'($urandom), 4'($urandom_range(0, 11)));
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_start();
    t_ovf();
    t_random();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule